// File: doc/BRIEF.md
# Address match breakpoint unit

This block decides, in the same cycle, whether the current instruction must be stopped by a hardware breakpoint. It holds no state. It reads a set of triggers, each given as a control word and a compare address. It checks every trigger against the instruction fetch address and against the data access of the current instruction. When any trigger hits, it raises a breakpoint request together with the index of the trigger that won. The core then takes the exception before the fetch or access has any effect.

Each trigger is armed by two groups of bits in its control word. One group holds privilege enables and the other holds access kinds. At least one bit of each group must be set for the trigger to fire. An execute watch compares the fetch PC exactly. A data watch covers a window of bytes that starts at the compare address. The access counts as a hit when its byte range overlaps that window. Storage of the control words and the trap sequence belong to the surrounding core.

Control word fields, counted from bit 0: load enable at 0, store enable at 1, execute enable at 2, user enable at 3, supervisor enable at 4, machine enable at 6, low size code at [17:16], high size code at [22:21] (only used when XLEN is 64), and trigger kind in the top four bits.

Top module: `bp_addr_match_unit`

## Requirements
- R1: A trigger with none of its privilege enables (bits 3, 4, 6) set, or none of its kind enables (bits 0, 1, 2) set, never produces a hit.
- R2: An execute hit occurs when fetch_valid is 1, execute enable (bit 2) is set and fetch_pc equals the compare address exactly.
- R3: A data hit occurs when load enable (bit 0) is set and mem_rd is 1, or store enable (bit 1) is set and mem_wr is 1, and the access range [mem_addr, mem_addr+mem_len) overlaps the watch window that starts at the compare address.
- R4: Every hit is qualified by the privilege level: level 0 needs bit 3, level 1 needs bit 4, level 3 needs bit 6, and level 2 never hits.
- R5: The watch window width comes from the size code ({high, low}): 1 gives 1 byte, 2 gives 2 bytes, 3 gives 4 bytes, 5 gives 8 bytes, and 0 or any other code gives 8 bytes.
- R6: A trigger whose top four control bits are not 2 never produces a hit.
- R7: When several triggers hit at once, brk_idx reports the lowest-numbered one.
- R8: brk_req is combinational and follows its inputs in the same cycle. While brk_req is 0, brk_idx is 0.
- R9: Execute and data hits are gated independently: execute enable alone never matches a data access, and load or store enable alone never matches a fetch.
- R10: An access with mem_len of 0 never produces a data hit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fetch_valid | input | 1 | Fetch address is present this cycle |
| fetch_pc | input | XLEN | Instruction fetch address |
| mem_rd | input | 1 | Current instruction performs a read |
| mem_wr | input | 1 | Current instruction performs a write |
| mem_addr | input | XLEN | First byte address of the data access |
| mem_len | input | 4 | Access length in bytes (0 to 8) |
| priv | input | 2 | Current privilege level |
| trig_ctrl | input | NTRIG*XLEN | Control words, trigger i at [i*XLEN +: XLEN] |
| trig_cmp | input | NTRIG*XLEN | Compare addresses, trigger i at [i*XLEN +: XLEN] |
| brk_req | output | 1 | Breakpoint request |
| brk_idx | output | IDXW | Index of the winning trigger |

## Verification
The block keeps no state, so any fault shows at the ports in the same cycle as the stimulus that exposes it. A wrong window width or a wrong overlap bound shows only when an access sits at the window edge. A wrong privilege decode shows only when the privilege level hits the one missing enable. A priority error shows only when two triggers hit together. The stimulus therefore places accesses exactly on the window edges, sweeps all four privilege levels, and arms overlapping triggers. Every cycle is compared against a behavioural model.

// File: rtl/bp_pkg.sv
package bp_pkg;
  // control word field positions (the CSR side decodes the same layout)
  localparam int unsigned CB_LOAD  = 0;
  localparam int unsigned CB_STORE = 1;
  localparam int unsigned CB_EXEC  = 2;
  localparam int unsigned CB_USER  = 3;
  localparam int unsigned CB_SUPV  = 4;
  localparam int unsigned CB_MACH  = 6;
  localparam int unsigned CB_SZLO  = 16;
  localparam int unsigned CB_SZHI  = 21;
  localparam int unsigned KIND_W   = 4;
  localparam logic [3:0]  KIND_ADDR = 4'd2;
  localparam int unsigned LEN_W    = 4;

  typedef enum logic [1:0] {
    PL_USER = 2'd0,
    PL_SUPV = 2'd1,
    PL_RSVD = 2'd2,
    PL_MACH = 2'd3
  } priv_e;

  // byte width of a watch window from the 4-bit size code
  function automatic logic [LEN_W-1:0] win_bytes(input logic [3:0] code);
    case (code)
      4'd1:    win_bytes = 4'd1;
      4'd2:    win_bytes = 4'd2;
      4'd3:    win_bytes = 4'd4;
      default: win_bytes = 4'd8;
    endcase
  endfunction
endpackage

// File: rtl/bp_trig_match.sv
module bp_trig_match
  import bp_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0]  ctrl,
  input  logic [XLEN-1:0]  cmp,
  input  logic             fetch_valid,
  input  logic [XLEN-1:0]  fetch_pc,
  input  logic             mem_rd,
  input  logic             mem_wr,
  input  logic [XLEN-1:0]  mem_addr,
  input  logic [LEN_W-1:0] mem_len,
  input  logic [1:0]       priv,
  output logic             exec_hit,
  output logic             data_hit
);
  localparam int unsigned KIND_LSB = XLEN - KIND_W;

  logic       kind_ok;
  logic       priv_ok;
  logic       armed;
  logic [3:0] size_code;
  logic [LEN_W-1:0] win_w;
  logic [XLEN:0] acc_lo, acc_end, win_lo, win_end;
  logic       overlap;
  logic       dir_ok;
  logic       unused_ctrl;

  assign unused_ctrl = ^ctrl;
  assign kind_ok = (ctrl[KIND_LSB +: KIND_W] == KIND_ADDR);

  always_comb begin
    case (priv_e'(priv))
      PL_USER: priv_ok = ctrl[CB_USER];
      PL_SUPV: priv_ok = ctrl[CB_SUPV];
      PL_MACH: priv_ok = ctrl[CB_MACH];
      default: priv_ok = 1'b0;
    endcase
  end

  assign armed = kind_ok && priv_ok &&
                 (ctrl[CB_LOAD] || ctrl[CB_STORE] || ctrl[CB_EXEC]);

  generate
    if (XLEN >= 64) begin : g_wide_size
      assign size_code = {ctrl[CB_SZHI +: 2], ctrl[CB_SZLO +: 2]};
    end else begin : g_narrow_size
      assign size_code = {2'b00, ctrl[CB_SZLO +: 2]};
    end
  endgenerate

  assign win_w   = win_bytes(size_code);
  assign acc_lo  = {1'b0, mem_addr};
  assign acc_end = acc_lo + {{(XLEN+1-LEN_W){1'b0}}, mem_len};
  assign win_lo  = {1'b0, cmp};
  assign win_end = win_lo + {{(XLEN+1-LEN_W){1'b0}}, win_w};
  assign overlap = (mem_len != '0) && (acc_lo < win_end) && (win_lo < acc_end);
  assign dir_ok  = (ctrl[CB_LOAD] && mem_rd) || (ctrl[CB_STORE] && mem_wr);

  assign exec_hit = armed && fetch_valid && ctrl[CB_EXEC] && (fetch_pc == cmp);
  assign data_hit = armed && dir_ok && overlap;
endmodule

// File: rtl/bp_prio_pick.sv
module bp_prio_pick #(
  parameter int unsigned N    = 4,
  parameter int unsigned IDXW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]    hits,
  output logic            any,
  output logic [IDXW-1:0] idx
);
  assign any = |hits;

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hits[i]) idx = IDXW'(i);
    end
  end
endmodule

// File: rtl/bp_addr_match_unit.sv
module bp_addr_match_unit
  import bp_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned NTRIG = 4,
  localparam int unsigned IDXW = (NTRIG > 1) ? $clog2(NTRIG) : 1
) (
  input  logic                  fetch_valid,
  input  logic [XLEN-1:0]       fetch_pc,
  input  logic                  mem_rd,
  input  logic                  mem_wr,
  input  logic [XLEN-1:0]       mem_addr,
  input  logic [LEN_W-1:0]      mem_len,
  input  logic [1:0]            priv,
  input  logic [NTRIG*XLEN-1:0] trig_ctrl,
  input  logic [NTRIG*XLEN-1:0] trig_cmp,
  output logic                  brk_req,
  output logic [IDXW-1:0]       brk_idx
);
  logic [NTRIG-1:0] ex_hit;
  logic [NTRIG-1:0] dt_hit;
  logic [NTRIG-1:0] any_hit;

  generate
    for (genvar g = 0; g < NTRIG; g++) begin : g_trig
      bp_trig_match #(.XLEN(XLEN)) u_match (
        .ctrl        (trig_ctrl[g*XLEN +: XLEN]),
        .cmp         (trig_cmp[g*XLEN +: XLEN]),
        .fetch_valid (fetch_valid),
        .fetch_pc    (fetch_pc),
        .mem_rd      (mem_rd),
        .mem_wr      (mem_wr),
        .mem_addr    (mem_addr),
        .mem_len     (mem_len),
        .priv        (priv),
        .exec_hit    (ex_hit[g]),
        .data_hit    (dt_hit[g])
      );
    end
  endgenerate

  assign any_hit = ex_hit | dt_hit;

  bp_prio_pick #(.N(NTRIG), .IDXW(IDXW)) u_pick (
    .hits (any_hit),
    .any  (brk_req),
    .idx  (brk_idx)
  );
endmodule

// File: rtl/bp_addr_match_chk.sv
module bp_addr_match_chk
  import bp_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned NTRIG = 4,
  parameter int unsigned IDXW  = 2
) (
  input logic                  fetch_valid,
  input logic                  mem_rd,
  input logic                  mem_wr,
  input logic [1:0]            priv,
  input logic [NTRIG*XLEN-1:0] trig_ctrl,
  input logic                  brk_req,
  input logic [IDXW-1:0]       brk_idx
);
  logic [XLEN-1:0] sel_ctrl;
  assign sel_ctrl = trig_ctrl[brk_idx*XLEN +: XLEN];

  always_comb begin
    // R8: a request only appears alongside a fetch or an access
    p_req_has_source_r8: assert (!brk_req || fetch_valid || mem_rd || mem_wr)
      else $error("request without fetch or access");
    // R8: index rests at zero while idle
    p_idle_index_r8: assert (brk_req || (brk_idx == '0))
      else $error("nonzero index without request");
    // R4: reserved privilege level never hits
    p_rsvd_priv_r4: assert (!(brk_req && priv == 2'd2))
      else $error("hit at reserved privilege level");
    // R6: the winner carries the address-match kind
    p_winner_kind_r6: assert (!brk_req || sel_ctrl[XLEN-1 -: KIND_W] == KIND_ADDR)
      else $error("winner has wrong trigger kind");
    // R1: the winner is armed in both enable groups
    p_winner_armed_r1: assert (!brk_req ||
        ((sel_ctrl[CB_USER] || sel_ctrl[CB_SUPV] || sel_ctrl[CB_MACH]) &&
         (sel_ctrl[CB_LOAD] || sel_ctrl[CB_STORE] || sel_ctrl[CB_EXEC])))
      else $error("winner lacks enables");
  end
endmodule

bind bp_addr_match_unit bp_addr_match_chk #(
  .XLEN(XLEN), .NTRIG(NTRIG), .IDXW(IDXW)
) u_chk (
  .fetch_valid (fetch_valid),
  .mem_rd      (mem_rd),
  .mem_wr      (mem_wr),
  .priv        (priv),
  .trig_ctrl   (trig_ctrl),
  .brk_req     (brk_req),
  .brk_idx     (brk_idx)
);

// File: tb/bp_addr_match_unit_test.sv
module bp_addr_match_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int XL = 32;
  localparam int NT = 4;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          fetch_valid, mem_rd, mem_wr;
  logic [XL-1:0] fetch_pc, mem_addr;
  logic [3:0]    mem_len;
  logic [1:0]    priv;
  logic [XL-1:0] c [NT];
  logic [XL-1:0] a [NT];
  logic [NT*XL-1:0] trig_ctrl, trig_cmp;
  logic          brk_req;
  logic [1:0]    brk_idx;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  always_comb begin
    for (int i = 0; i < NT; i++) begin
      trig_ctrl[i*XL +: XL] = c[i];
      trig_cmp[i*XL +: XL]  = a[i];
    end
  end

  bp_addr_match_unit #(.XLEN(XL), .NTRIG(NT)) uut (
    .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_len(mem_len),
    .priv(priv), .trig_ctrl(trig_ctrl), .trig_cmp(trig_cmp),
    .brk_req(brk_req), .brk_idx(brk_idx)
  );

  // control word builder: kind, privilege mask {M,S,U}, kind mask {X,W,R}, size
  function automatic logic [XL-1:0] mk(int kind, int pm, int km, int sz);
    logic [XL-1:0] w = '0;
    w[31:28] = kind[3:0];
    w[3] = pm[0]; w[4] = pm[1]; w[6] = pm[2];
    w[0] = km[0]; w[1] = km[1]; w[2] = km[2];
    w[17:16] = sz[1:0];
    return w;
  endfunction

  // behavioural reference
  task automatic model(output bit req, output int idx);
    req = 0; idx = 0;
    for (int i = NT - 1; i >= 0; i--) begin
      longint lo, hi, wl, wh, width;
      bit pen, hit;
      case (priv)
        2'd0: pen = c[i][3];
        2'd1: pen = c[i][4];
        2'd3: pen = c[i][6];
        default: pen = 0;
      endcase
      case (c[i][17:16])
        2'd1: width = 1;
        2'd2: width = 2;
        2'd3: width = 4;
        default: width = 8;
      endcase
      lo = longint'(mem_addr); hi = lo + longint'(mem_len);
      wl = longint'(a[i]);     wh = wl + width;
      hit = 0;
      if (c[i][31:28] == 4'd2 && pen) begin
        if (fetch_valid && c[i][2] && fetch_pc == a[i]) hit = 1;
        if (((c[i][0] && mem_rd) || (c[i][1] && mem_wr)) && mem_len != 0 &&
            lo < wh && wl < hi) hit = 1;
      end
      if (hit) begin req = 1; idx = i; end
    end
  endtask

  task automatic idle();
    fetch_valid = 0; fetch_pc = '0; mem_rd = 0; mem_wr = 0;
    mem_addr = '0; mem_len = '0; priv = 2'd3;
  endtask

  task automatic check(string tag);
    bit er; int ei;
    @(negedge clk);
    model(er, ei);
    vectors++;
    if (brk_req !== er || (int'(brk_idx) != ei)) begin
      miscompares++;
      $display("FAIL %s: got req=%0d idx=%0d, expected req=%0d idx=%0d",
               tag, brk_req, brk_idx, er, ei);
    end
    @(posedge clk);
  endtask

  task automatic dat(logic [XL-1:0] ad, int len, bit rd, bit wr, string tag);
    idle(); mem_addr = ad; mem_len = len[3:0]; mem_rd = rd; mem_wr = wr;
    check(tag);
  endtask

  task automatic clear();
    for (int i = 0; i < NT; i++) begin c[i] = '0; a[i] = '0; end
  endtask

  initial begin
    clear(); idle();
    @(posedge clk);
    check("R8 idle");

    // execute watch
    c[0] = mk(2, 3'b100, 3'b100, 0); a[0] = 32'h1000;
    idle(); fetch_valid = 1; fetch_pc = 32'h1000; check("R2 exec hit");
    fetch_pc = 32'h1004; check("R2 exec miss");
    fetch_valid = 0; fetch_pc = 32'h1000; check("R2 fetch not valid");
    fetch_valid = 1; priv = 2'd0; check("R4 user level not enabled");
    priv = 2'd2; check("R4 reserved level");
    c[0] = mk(2, 3'b111, 3'b100, 0); priv = 2'd2; check("R4 reserved all enables");
    priv = 2'd1; check("R4 supervisor");
    c[0] = mk(2, 3'b000, 3'b100, 0); check("R1 no privilege bits");
    c[0] = mk(2, 3'b111, 3'b000, 0); check("R1 no kind bits");
    c[0] = mk(3, 3'b111, 3'b100, 0); check("R6 wrong kind");
    c[0] = mk(2, 3'b111, 3'b011, 0); check("R9 data bits vs fetch");

    // data watches, size 0 = 8 bytes
    clear(); c[1] = mk(2, 3'b100, 3'b001, 0); a[1] = 32'h2000;
    dat(32'h2007, 1, 1, 0, "R5 size0 last byte");
    dat(32'h2008, 1, 1, 0, "R5 size0 past end");
    dat(32'h1FFD, 4, 1, 0, "R3 overlap from below");
    dat(32'h1FFD, 3, 1, 0, "R3 ends before window");
    dat(32'h2000, 4, 0, 1, "R3 write on load watch");
    dat(32'h2000, 0, 1, 0, "R10 zero length");
    c[1] = mk(2, 3'b100, 3'b010, 0);
    dat(32'h2004, 2, 0, 1, "R3 store hit");
    c[1] = mk(2, 3'b100, 3'b100, 0);
    dat(32'h2000, 4, 1, 1, "R9 exec bit vs access");
    c[1] = mk(2, 3'b100, 3'b001, 1);
    dat(32'h2001, 1, 1, 0, "R5 size1 next byte");
    c[1] = mk(2, 3'b100, 3'b001, 2);
    dat(32'h2001, 1, 1, 0, "R5 size2 second byte");
    dat(32'h2002, 1, 1, 0, "R5 size2 past end");
    c[1] = mk(2, 3'b100, 3'b001, 3);
    dat(32'h2003, 1, 1, 0, "R5 size3 last byte");
    dat(32'h2004, 1, 1, 0, "R5 size3 past end");

    // priority
    c[3] = mk(2, 3'b100, 3'b001, 0); a[3] = 32'h2000;
    c[2] = mk(2, 3'b100, 3'b001, 0); a[2] = 32'h2004;
    dat(32'h2003, 2, 1, 0, "R7 lowest wins");
    c[1] = '0;
    dat(32'h2005, 1, 1, 0, "R7 two hits");

    // random sweep near a small address region
    for (int n = 0; n < 4000; n++) begin
      for (int i = 0; i < NT; i++) begin
        c[i] = mk(($urandom % 8 == 0) ? int'($urandom % 16) : 2,
                  int'($urandom % 8), int'($urandom % 8), int'($urandom % 4));
        a[i] = 32'h3000 + ($urandom % 24);
      end
      fetch_valid = $urandom % 2; fetch_pc = 32'h3000 + ($urandom % 24);
      mem_rd = $urandom % 2; mem_wr = $urandom % 2;
      mem_addr = 32'h2FF8 + ($urandom % 40); mem_len = 4'($urandom % 9);
      priv = 2'($urandom % 4);
      check("RND R1 R2 R3 R4 R5 R6 R7");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule